// File: doc/BRIEF.md
# HDLC Frame Receive Controller

This block runs the frame-level receive sequence of a bit-oriented synchronous serial link. It takes one received bit per clock enable and finds the 01111110 flag pattern. It removes the zeros the transmitter inserted after runs of five ones and assembles 8-bit characters, least significant bit first. It then decides, frame by frame, whether to pass the characters on. Accepted characters go out on a one-cycle write port toward a receive buffer. The last written character of a good frame carries an end-of-frame mark. Frames that end too early, or that are cut off by an abort, are reported on separate one-cycle status pulses.

The receiver moves through five states: off, hunting for a flag, waiting for the first character after the flags, checking the address, and receiving. The first character of a frame is compared against a station address. A match admits the frame, and a mismatch sends the receiver back to hunt for a flag. A bypass input skips that comparison. A mode input chooses whether the two trailing frame check characters are forwarded or withheld. The block does not compute the check sequence itself. It only decides which characters reach the buffer.

Top module: `hdlc_rx_ctrl`

## Requirements
- R1: While `rxEn` is low, or in any cycle where `rxReset` is high, the receiver is off. Serial input is ignored and nothing is written or reported. After `rxReset`, a frame already in progress is not resumed, and reception restarts only at the next flag.
- R2: A flag is the bit sequence 0,1,1,1,1,1,1,0. Characters are assembled least significant bit first. After a flag, every character of an accepted frame, the address included, is written in arrival order. `wrEof` is set on the last write of the frame.
- R3: Repeated flags between the opening flag and the first character are ignored and do not start a frame.
- R4: One flag may close one frame and open the next. Both frames are written completely, and each ends with its own end-of-frame write.
- R5: When the first character differs from `stationAddr` and bypass is off, the frame produces no writes and no status. The next frame is received normally.
- R6: With `addrBypass` high, a frame is accepted whatever its first character is.
- R7: A 0 that follows five consecutive 1s inside a frame is removed before assembly. Characters such as 0xFF and 0x7E are therefore received intact.
- R8: A flag that arrives when fewer than three characters have followed the address marks a short frame. The block pulses `wrShort`, makes no end-of-frame write, and goes on waiting for the next frame.
- R9: With `fcsHold` high, the two characters before the closing flag are withheld and `wrEof` marks the last character before them. With `fcsHold` low, those two characters are written too.
- R10: Seven consecutive 1s inside an accepted frame pulse `wrAbort`, drop the frame without an end-of-frame write, and return the receiver to flag hunting.
- R11: `wrStrobe`, `wrEof`, `wrShort` and `wrAbort` are single-cycle pulses. `wrEof` is only set together with `wrStrobe`, and a status pulse never coincides with a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| rxEn | input | 1 | Receiver enable; low holds the receiver off |
| rxReset | input | 1 | Synchronous receiver reset command |
| addrBypass | input | 1 | Skip the station address comparison |
| fcsHold | input | 1 | Withhold the two trailing check characters |
| stationAddr | input | 8 | Station address for frame filtering |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Received serial bit |
| wrData | output | 8 | Character to the receive buffer |
| wrStrobe | output | 1 | Write strobe for `wrData` |
| wrEof | output | 1 | Marks the last character of a frame |
| wrShort | output | 1 | Short frame detected |
| wrAbort | output | 1 | Accepted frame aborted |

## Verification
Two situations are the hardest to reach from the ports. The first is a flag that closes one frame and opens the next. The second is a run of ones that must be read as data, as a stuffing boundary or as an abort, depending only on how long it is. The bench builds its serial streams bit by bit and inserts the zeros itself from its own run-of-ones count. This lets it place 0xFF and 0x7E characters next to character boundaries, chain frames on a single flag, and cut a frame with seven raw ones, after which a good frame has to be received. Short frames are reached by ending a frame two characters after its address, and the same test is repeated with the trailing characters withheld.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [2:0] {
    RX_OFF,
    RX_HUNT,
    RX_GAP,
    RX_ADDR,
    RX_DATA
  } rxState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic listen;
    logic load;
    logic push;
    logic flush;
    logic markShort;
    logic markAbort;
  } rxCtl_t;

  // datapath -> control events (registered)
  typedef struct packed {
    logic evFlag;
    logic evAbort;
    logic evChar;
    logic addrMatch;
  } rxEvt_t;

endpackage

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int FCS_CHARS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic [CHAR_W-1:0] stationAddr,
  input  logic              fcsHold,
  input  rxCtl_t            ctl,
  output rxEvt_t            evt,
  output logic [CHAR_W-1:0] wrData,
  output logic              wrStrobe,
  output logic              wrEof,
  output logic              wrShort,
  output logic              wrAbort
);

  localparam int QDEPTH    = FCS_CHARS + 1;
  localparam int QCW       = $clog2(QDEPTH + 1);
  localparam int BCW       = $clog2(CHAR_W);
  localparam int ONES_W    = 3;
  localparam int STUFF_RUN = 5;
  localparam int FLAG_RUN  = 6;

  logic [ONES_W-1:0] onesCnt;
  logic [BCW-1:0]    bitCnt;
  logic [CHAR_W-1:0] shiftReg, charOut, newChar;
  logic [CHAR_W-1:0] qMem [QDEPTH];
  logic [QCW-1:0]    qCnt, depthNow, tailIdx;
  logic              bitOk, stuffHit, flagHit, abortHit, dataBit, charHit;
  logic              evFlagQ, evAbortQ, evCharQ;

  assign bitOk    = bitValid && ctl.listen;
  assign stuffHit = bitOk && !bitIn && (onesCnt == ONES_W'(STUFF_RUN));
  assign flagHit  = bitOk && !bitIn && (onesCnt == ONES_W'(FLAG_RUN));
  assign abortHit = bitOk &&  bitIn && (onesCnt == ONES_W'(FLAG_RUN));
  assign dataBit  = bitOk && !stuffHit && !flagHit && !abortHit;
  assign newChar  = {bitIn, shiftReg[CHAR_W-1:1]};
  assign charHit  = dataBit && (bitCnt == BCW'(CHAR_W - 1));

  assign depthNow = fcsHold ? QCW'(QDEPTH) : QCW'(1);
  assign tailIdx  = depthNow - QCW'(1);

  assign evt.evFlag    = evFlagQ;
  assign evt.evAbort   = evAbortQ;
  assign evt.evChar    = evCharQ;
  assign evt.addrMatch = (charOut == stationAddr);

  // bit level: run counting, flag/abort detection, stuffing removal, assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt  <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      charOut  <= '0;
      evFlagQ  <= 1'b0;
      evAbortQ <= 1'b0;
      evCharQ  <= 1'b0;
    end else if (!ctl.listen) begin
      onesCnt  <= '0;
      bitCnt   <= '0;
      evFlagQ  <= 1'b0;
      evAbortQ <= 1'b0;
      evCharQ  <= 1'b0;
    end else begin
      evFlagQ  <= flagHit;
      evAbortQ <= abortHit;
      evCharQ  <= charHit;
      if (bitOk) begin
        if (!bitIn)                            onesCnt <= '0;
        else if (onesCnt != {ONES_W{1'b1}})    onesCnt <= onesCnt + 1'b1;
      end
      if (flagHit || abortHit) begin
        bitCnt <= '0;
      end else if (dataBit) begin
        shiftReg <= newChar;
        if (charHit) begin
          bitCnt  <= '0;
          charOut <= newChar;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // character delay line and write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qCnt     <= '0;
      wrData   <= '0;
      wrStrobe <= 1'b0;
      wrEof    <= 1'b0;
      wrShort  <= 1'b0;
      wrAbort  <= 1'b0;
      for (int i = 0; i < QDEPTH; i++) qMem[i] <= '0;
    end else begin
      wrStrobe <= 1'b0;
      wrEof    <= 1'b0;
      wrShort  <= ctl.markShort;
      wrAbort  <= ctl.markAbort;
      if (ctl.load) begin
        qMem[0] <= charOut;
        qCnt    <= QCW'(1);
      end else if (ctl.push) begin
        if (qCnt == depthNow) begin
          wrStrobe <= 1'b1;
          wrData   <= qMem[tailIdx];
        end else begin
          qCnt <= qCnt + 1'b1;
        end
        for (int i = 1; i < QDEPTH; i++) qMem[i] <= qMem[i-1];
        qMem[0] <= charOut;
      end else if (ctl.flush && (qCnt == depthNow)) begin
        wrStrobe <= 1'b1;
        wrEof    <= 1'b1;
        wrData   <= qMem[tailIdx];
      end
    end
  end

  // R1: nothing leaves the port after a cycle spent off
  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.listen |=> !(wrStrobe || wrShort || wrAbort));

  // R11: end-of-frame mark only on a write
  p_eof_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrEof |-> wrStrobe);

  // R11: single-cycle end-of-frame pulse
  p_eof_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrEof |=> !wrEof);

  // R9: the controller only closes a frame whose delay line is full
  p_flush_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |-> (qCnt == depthNow));

  // R8: status pulses stand alone
  p_status_alone_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrShort |-> (!wrStrobe && !wrAbort));

endmodule

// File: rtl/hdlc_rx_control.sv
module hdlc_rx_control
  import hdlc_rx_pkg::*;
#(
  parameter int SHORT_LIMIT = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxEn,
  input  logic   rxReset,
  input  logic   addrBypass,
  input  rxEvt_t evt,
  output rxCtl_t ctl
);

  localparam int CCW = $clog2(SHORT_LIMIT + 1);

  rxState_t       state, nxt;
  logic [CCW-1:0] charCnt, charCntNxt;

  always_comb begin
    nxt        = state;
    charCntNxt = charCnt;
    ctl        = '0;
    if (!rxEn || rxReset) begin
      nxt = RX_OFF;
    end else begin
      unique case (state)
        RX_OFF: nxt = RX_HUNT;
        RX_HUNT: begin
          ctl.listen = 1'b1;
          if (evt.evFlag) nxt = RX_GAP;
        end
        RX_GAP: begin
          ctl.listen = 1'b1;
          if (evt.evAbort) begin
            nxt = RX_HUNT;
          end else if (evt.evChar) begin
            if (addrBypass) begin
              ctl.load   = 1'b1;
              charCntNxt = '0;
              nxt        = RX_DATA;
            end else begin
              nxt = RX_ADDR;
            end
          end
        end
        RX_ADDR: begin
          ctl.listen = 1'b1;
          if (evt.evAbort || !evt.addrMatch) begin
            nxt = RX_HUNT;
          end else begin
            ctl.load   = 1'b1;
            charCntNxt = '0;
            nxt        = RX_DATA;
          end
        end
        RX_DATA: begin
          ctl.listen = 1'b1;
          if (evt.evAbort) begin
            ctl.markAbort = 1'b1;
            nxt           = RX_HUNT;
          end else if (evt.evFlag) begin
            if (charCnt < CCW'(SHORT_LIMIT)) ctl.markShort = 1'b1;
            else                             ctl.flush     = 1'b1;
            nxt = RX_GAP;
          end else if (evt.evChar) begin
            ctl.push = 1'b1;
            if (charCnt != CCW'(SHORT_LIMIT)) charCntNxt = charCnt + 1'b1;
          end
        end
        default: nxt = RX_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_OFF;
      charCnt <= '0;
    end else begin
      state   <= nxt;
      charCnt <= charCntNxt;
    end
  end

  // R5: a failed address comparison returns to flag hunting
  p_mismatch_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_ADDR && rxEn && !rxReset && !evt.addrMatch) |=> (state == RX_HUNT));

  // R10: an abort inside a frame always ends in flag hunting
  p_abort_hunt_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.markAbort |=> (state == RX_HUNT || state == RX_OFF));

endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int FCS_CHARS   = 2,
  parameter int SHORT_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              rxReset,
  input  logic              addrBypass,
  input  logic              fcsHold,
  input  logic [CHAR_W-1:0] stationAddr,
  input  logic              bitValid,
  input  logic              bitIn,
  output logic [CHAR_W-1:0] wrData,
  output logic              wrStrobe,
  output logic              wrEof,
  output logic              wrShort,
  output logic              wrAbort
);

  rxCtl_t ctl;
  rxEvt_t evt;

  hdlc_rx_control #(.SHORT_LIMIT(SHORT_LIMIT)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .rxEn       (rxEn),
    .rxReset    (rxReset),
    .addrBypass (addrBypass),
    .evt        (evt),
    .ctl        (ctl)
  );

  hdlc_rx_datapath #(.CHAR_W(CHAR_W), .FCS_CHARS(FCS_CHARS)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .bitValid    (bitValid),
    .bitIn       (bitIn),
    .stationAddr (stationAddr),
    .fcsHold     (fcsHold),
    .ctl         (ctl),
    .evt         (evt),
    .wrData      (wrData),
    .wrStrobe    (wrStrobe),
    .wrEof       (wrEof),
    .wrShort     (wrShort),
    .wrAbort     (wrAbort)
  );

endmodule

// File: tb/hdlc_rx_ctrl_tb.sv
`timescale 1ns/1ps
module hdlc_rx_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEn = 1'b1, rxReset = 1'b0, addrBypass = 1'b0, fcsHold = 1'b0;
  logic [7:0] stationAddr = 8'h5A;
  logic       bitValid = 1'b0, bitIn = 1'b1;
  logic [7:0] wrData;
  logic       wrStrobe, wrEof, wrShort, wrAbort;

  always #10 clk = ~clk;

  hdlc_rx_ctrl u_dut (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxReset(rxReset),
    .addrBypass(addrBypass), .fcsHold(fcsHold), .stationAddr(stationAddr),
    .bitValid(bitValid), .bitIn(bitIn), .wrData(wrData), .wrStrobe(wrStrobe),
    .wrEof(wrEof), .wrShort(wrShort), .wrAbort(wrAbort)
  );

  int nChecks = 0, nErr = 0, txOnes = 0;
  int wrCnt = 0, shortCnt = 0, abortCnt = 0, badPulse = 0;
  logic [7:0] logData [256];
  logic       logEof  [256];
  logic       prevStrobe = 1'b0;
  logic [7:0] txBuf [8];
  int         txLen = 0;
  logic [7:0] expBuf [8];
  int         expLen = 0;

  // write-port monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (wrStrobe) begin
        logData[wrCnt[7:0]] = wrData;
        logEof[wrCnt[7:0]]  = wrEof;
        wrCnt++;
      end
      if (wrEof && !wrStrobe) badPulse++;
      if (wrStrobe && prevStrobe) badPulse++;
      if ((wrShort || wrAbort) && wrStrobe) badPulse++;
      if (wrShort) shortCnt++;
      if (wrAbort) abortCnt++;
      prevStrobe = wrStrobe;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rawBit(input logic b);
    @(negedge clk); bitValid = 1'b1; bitIn = b;
    @(negedge clk); bitValid = 1'b0;
  endtask

  task automatic dataBit(input logic b);
    rawBit(b);
    if (b) txOnes++; else txOnes = 0;
    if (txOnes == 5) begin rawBit(1'b0); txOnes = 0; end
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) dataBit(v[i]);
  endtask

  task automatic sendFlag();
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) rawBit(f[i]);
    txOnes = 0;
  endtask

  task automatic sendAbort();
    for (int i = 0; i < 7; i++) rawBit(1'b1);
    txOnes = 0;
  endtask

  task automatic loadTx(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5);
    txLen = n;
    txBuf[0] = b0; txBuf[1] = b1; txBuf[2] = b2;
    txBuf[3] = b3; txBuf[4] = b4; txBuf[5] = b5;
    expLen = n;
    for (int i = 0; i < 8; i++) expBuf[i] = txBuf[i];
  endtask

  task automatic sendBody();
    for (int i = 0; i < txLen; i++) sendByte(txBuf[i]);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  // compare writes logged since base against expBuf[0..expLen-1]
  task automatic expectWrites(input string req, input int base, input bit eofLast);
    chk(wrCnt - base == expLen, req, "write count", wrCnt - base, expLen);
    for (int i = 0; i < expLen && base + i < wrCnt; i++) begin
      chk(logData[base+i] == expBuf[i], req, "data", logData[base+i], expBuf[i]);
      chk(logEof[base+i] == (eofLast && i == expLen - 1), req, "eof",
          logEof[base+i], (eofLast && i == expLen - 1));
    end
  endtask

  task automatic t_reset();
    chk(wrStrobe == 0 && wrEof == 0 && wrShort == 0 && wrAbort == 0, "R1",
        "outputs after reset", {wrStrobe, wrEof, wrShort, wrAbort}, 0);
  endtask

  task automatic t_basic();
    int base = wrCnt;
    sendFlag(); sendFlag(); sendFlag();   // R3: repeated opening flags
    loadTx(5, 8'h5A, 8'h11, 8'h22, 8'hC3, 8'h3C, 8'h00);
    sendBody(); sendFlag(); settle();
    expectWrites("R2", base, 1'b1);
    chk(wrCnt - base == 5, "R3", "frame after repeated flags", wrCnt - base, 5);
  endtask

  task automatic t_shared();
    int base = wrCnt;
    loadTx(4, 8'h5A, 8'h01, 8'h02, 8'h03, 8'h00, 8'h00);
    sendBody(); sendFlag();               // closes frame 1, opens frame 2
    settle();
    expectWrites("R4", base, 1'b1);
    base = wrCnt;
    loadTx(5, 8'h5A, 8'h04, 8'h05, 8'h06, 8'h07, 8'h00);
    sendBody(); sendFlag(); settle();
    expectWrites("R4", base, 1'b1);
  endtask

  task automatic t_mismatch();
    int base = wrCnt, sBase = shortCnt, aBase = abortCnt;
    loadTx(5, 8'h77, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00);
    sendBody(); sendFlag(); settle();
    chk(wrCnt == base, "R5", "writes for foreign address", wrCnt - base, 0);
    chk(shortCnt == sBase && abortCnt == aBase, "R5", "status for foreign address",
        shortCnt - sBase + abortCnt - aBase, 0);
    loadTx(4, 8'h5A, 8'h99, 8'h88, 8'h77, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    expectWrites("R5", base, 1'b1);
  endtask

  task automatic t_bypass();
    int base = wrCnt;
    addrBypass = 1'b1;
    loadTx(4, 8'hC1, 8'h10, 8'h20, 8'h30, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    expectWrites("R6", base, 1'b1);
    addrBypass = 1'b0;
  endtask

  task automatic t_stuff();
    int base = wrCnt, aBase = abortCnt;
    loadTx(6, 8'h5A, 8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'hFF);
    sendBody(); sendFlag(); settle();
    expectWrites("R7", base, 1'b1);
    chk(abortCnt == aBase, "R7", "no abort from stuffed ones", abortCnt - aBase, 0);
  endtask

  task automatic t_short();
    int base = wrCnt, sBase = shortCnt, eofs = 0;
    loadTx(3, 8'h5A, 8'h10, 8'h20, 8'h00, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    chk(shortCnt - sBase == 1, "R8", "short pulse count", shortCnt - sBase, 1);
    for (int i = base; i < wrCnt; i++) if (logEof[i]) eofs++;
    chk(eofs == 0, "R8", "eof in short frame", eofs, 0);
    base = wrCnt;
    loadTx(4, 8'h5A, 8'h31, 8'h32, 8'h33, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    expectWrites("R8", base, 1'b1);
  endtask

  task automatic t_fcshold();
    int base = wrCnt, sBase = shortCnt;
    fcsHold = 1'b1;
    loadTx(5, 8'h5A, 8'hA1, 8'hA2, 8'hF1, 8'hF2, 8'h00);
    sendBody(); sendFlag(); settle();
    expLen = 3;
    expectWrites("R9", base, 1'b1);
    base = wrCnt;
    loadTx(4, 8'h5A, 8'hB1, 8'hF1, 8'hF2, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    expLen = 2;
    expectWrites("R9", base, 1'b1);
    base = wrCnt;
    loadTx(3, 8'h5A, 8'hC1, 8'hC2, 8'h00, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    chk(wrCnt == base, "R9", "held short frame writes", wrCnt - base, 0);
    chk(shortCnt - sBase == 1, "R8", "held short frame pulse", shortCnt - sBase, 1);
    fcsHold = 1'b0;
  endtask

  task automatic t_abort();
    int base = wrCnt, aBase = abortCnt, eofs = 0;
    loadTx(3, 8'h5A, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00);
    sendBody(); sendAbort();
    loadTx(2, 8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 8'h00);
    sendBody();                            // ignored while hunting
    settle();
    chk(abortCnt - aBase == 1, "R10", "abort pulse count", abortCnt - aBase, 1);
    for (int i = base; i < wrCnt; i++) if (logEof[i]) eofs++;
    chk(eofs == 0, "R10", "eof in aborted frame", eofs, 0);
    sendFlag();
    base = wrCnt;
    loadTx(4, 8'h5A, 8'h41, 8'h42, 8'h43, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    expectWrites("R10", base, 1'b1);
  endtask

  task automatic t_disable();
    int base, sBase = shortCnt, aBase = abortCnt;
    rxEn = 1'b0;
    base = wrCnt;
    sendFlag();
    loadTx(5, 8'h5A, 8'h51, 8'h52, 8'h53, 8'h54, 8'h00);
    sendBody(); sendFlag();
    loadTx(2, 8'h5A, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00);
    sendBody(); sendAbort(); settle();
    chk(wrCnt == base, "R1", "writes while disabled", wrCnt - base, 0);
    chk(shortCnt == sBase && abortCnt == aBase, "R1", "status while disabled",
        shortCnt - sBase + abortCnt - aBase, 0);
    rxEn = 1'b1;
    sendFlag();
    loadTx(2, 8'h5A, 8'h61, 8'h00, 8'h00, 8'h00, 8'h00);
    sendBody();
    @(negedge clk); rxReset = 1'b1; @(negedge clk); rxReset = 1'b0;
    base = wrCnt;
    loadTx(3, 8'h62, 8'h63, 8'h64, 8'h00, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    chk(wrCnt == base, "R1", "writes after receiver reset", wrCnt - base, 0);
    base = wrCnt;
    loadTx(4, 8'h5A, 8'h71, 8'h72, 8'h73, 8'h00, 8'h00);
    sendBody(); sendFlag(); settle();
    expectWrites("R1", base, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    for (int i = 0; i < 10; i++) rawBit(1'b1);  // idle ones before the first flag
    t_basic();
    t_shared();
    t_mismatch();
    t_bypass();
    t_stuff();
    t_short();
    t_fcshold();
    t_abort();
    t_disable();
    chk(badPulse == 0, "R11", "pulse rule violations", badPulse, 0);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule